// File: doc/BRIEF.md
# Configurable Product-Term Macrocell

This block is one logic cell of a programmable array. A set of product terms is formed over an input bus, where each term is the AND of whichever true or inverted input literals its configuration enables. A subset of the first terms is ORed into a sum. An optional inversion then sets the polarity of that sum. The result reaches the pad either combinationally or through a storage bit that acts as a D or a T flip-flop. Three further product terms can serve as a local clock, a local asynchronous clear and a local output enable for the storage bit and the pad. Each one replaces a global line when its select bit is set.

A static configuration vector programs the whole cell. It is written while the global reset is held and is not changed during operation. The pad is modelled as a data output plus an output-enable output. The tri-state driver itself sits outside the block.

Top module: `mc_macrocell`

## Requirements
- R1: Term t uses config bits `cfg[t*2N +: 2N]`, where N is the input count. Bit i adds literal `in_bus[i]` and bit N+i adds `~in_bus[i]`. A term with no literal enabled is constant 1. A term that enables both literals of one input is constant 0.
- R2: Sum terms are indices 0..N_SUM-1. Bit `cfg[N_TERM*2N + t]` admits term t into the OR. A term whose bit is clear has no effect on the output.
- R3: Mode bit 0 (invert) inverts the sum before it reaches the bypass path or the storage bit.
- R4: With mode bit 1 (bypass) set, `pad_out` equals the polarity-adjusted sum in the same cycle, with no clock edge needed.
- R5: With mode bit 1 clear and mode bit 2 (toggle) clear, the storage bit loads the polarity-adjusted sum on each active clock edge, and `pad_out` shows it.
- R6: With mode bit 2 set, the storage bit inverts on an active clock edge when the polarity-adjusted sum is 1 and holds otherwise.
- R7: With mode bit 3 set, the storage bit is clocked by the rising edge of term N_SUM, and edges of `gclk` have no effect on it. With the bit clear, it is clocked by `gclk`.
- R8: With mode bit 4 clear, a low `rst_n` clears the storage bit to 0 at once. After `rst_n` rises, the first load happens on the third `gclk` rising edge.
- R9: With mode bit 4 set, term N_SUM+1 clears the storage bit asynchronously while it is high, and `rst_n` has no effect on the storage bit.
- R10: With mode bit 5 clear, `pad_oe` follows `g_oe`. With the bit set, `pad_oe` follows term N_SUM+2 and `g_oe` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk | input | 1 | Global clock |
| rst_n | input | 1 | Global asynchronous clear, active low |
| g_oe | input | 1 | Global output enable, active high |
| in_bus | input | N_IN | Literal inputs to the AND array |
| cfg | input | CFG_W | Static configuration: crosspoints, sum admits, mode bits |
| pad_out | output | 1 | Data toward the pad driver |
| pad_oe | output | 1 | Enable toward the pad driver |

## Verification
The bypass data path, `pad_oe` and both asynchronous clears settle without a clock, so those checks are made 1 time unit after the input changes. Registered results appear after one active edge. The bench drives inputs on the falling edge of `gclk` and checks at the next falling edge, which lies one rising edge later. With the product-term clock, it compares the output 1 time unit after it raises the clock literal. After the global reset is released, the bench waits three falling edges, because the two synchronizer stages delay the first load to the third rising edge.

// File: rtl/mc_pkg.sv
package mc_pkg;
  // Mode field, least significant member last
  typedef struct packed {
    logic oe_from_term;   // bit 5
    logic clr_from_term;  // bit 4
    logic clk_from_term;  // bit 3
    logic toggle_mode;    // bit 2
    logic bypass;         // bit 1
    logic invert;         // bit 0
  } mc_mode_t;

  localparam int MODE_W = $bits(mc_mode_t);
endpackage

// File: rtl/mc_and_array.sv
module mc_and_array #(
  parameter int N_IN   = 8,
  parameter int N_TERM = 8
) (
  input  logic [N_IN-1:0]          in_bus,
  input  logic [N_TERM*2*N_IN-1:0] xpt,
  output logic [N_TERM-1:0]        terms
);
  localparam int N_LIT = 2 * N_IN;

  logic [N_LIT-1:0] lits;
  assign lits = {~in_bus, in_bus};

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    // a literal not selected contributes a 1 to the AND
    assign terms[t] = &(lits | ~xpt[t*N_LIT +: N_LIT]);
  end
endmodule

// File: rtl/mc_or_alloc.sv
module mc_or_alloc #(
  parameter int N_SUM = 5
) (
  input  logic [N_SUM-1:0] sum_terms,
  input  logic [N_SUM-1:0] admit,
  input  logic             invert,
  output logic             sum_pol
);
  logic raw_sum;
  assign raw_sum = |(sum_terms & admit);
  assign sum_pol = raw_sum ^ invert;
endmodule

// File: rtl/mc_rst_sync.sv
module mc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage1     <= 1'b1;
      rst_sync_n <= stage1;
    end
  end
endmodule

// File: rtl/mc_store.sv
module mc_store (
  input  logic reg_clk,
  input  logic clr,
  input  logic toggle_mode,
  input  logic d_in,
  output logic q
);
  logic q_nxt;

  always_comb begin
    if (toggle_mode) q_nxt = q ^ d_in;
    else             q_nxt = d_in;
  end

  always_ff @(posedge reg_clk or posedge clr) begin
    if (clr) q <= 1'b0;
    else     q <= q_nxt;
  end
endmodule

// File: rtl/mc_macrocell.sv
module mc_macrocell
  import mc_pkg::*;
#(
  parameter int N_IN  = 8,
  parameter int N_SUM = 5,
  localparam int N_LIT  = 2 * N_IN,
  localparam int N_TERM = N_SUM + 3,
  localparam int XP_W   = N_TERM * N_LIT,
  localparam int CFG_W  = XP_W + N_SUM + MODE_W
) (
  input  logic             gclk,
  input  logic             rst_n,
  input  logic             g_oe,
  input  logic [N_IN-1:0]  in_bus,
  input  logic [CFG_W-1:0] cfg,
  output logic             pad_out,
  output logic             pad_oe
);
  localparam int CLK_T = N_SUM;
  localparam int CLR_T = N_SUM + 1;
  localparam int OE_T  = N_SUM + 2;

  mc_mode_t            mode;
  logic [N_TERM-1:0]   terms;
  logic                sum_pol;
  logic                rst_sync_n;
  logic                reg_clk;
  logic                reg_clr;
  logic                reg_q;

  assign mode = cfg[CFG_W-1 -: MODE_W];

  mc_and_array #(.N_IN(N_IN), .N_TERM(N_TERM)) i_and_array (
    .in_bus (in_bus),
    .xpt    (cfg[XP_W-1:0]),
    .terms  (terms)
  );

  mc_or_alloc #(.N_SUM(N_SUM)) i_or_alloc (
    .sum_terms (terms[N_SUM-1:0]),
    .admit     (cfg[XP_W +: N_SUM]),
    .invert    (mode.invert),
    .sum_pol   (sum_pol)
  );

  mc_rst_sync i_rst_sync (
    .clk        (gclk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign reg_clk = mode.clk_from_term ? terms[CLK_T] : gclk;
  assign reg_clr = mode.clr_from_term ? terms[CLR_T] : ~rst_sync_n;

  mc_store i_store (
    .reg_clk     (reg_clk),
    .clr         (reg_clr),
    .toggle_mode (mode.toggle_mode),
    .d_in        (sum_pol),
    .q           (reg_q)
  );

  assign pad_out = mode.bypass ? sum_pol : reg_q;
  assign pad_oe  = mode.oe_from_term ? terms[OE_T] : g_oe;
endmodule

// File: rtl/mc_macrocell_chk.sv
module mc_macrocell_chk
  import mc_pkg::*;
#(
  parameter int N_IN  = 8,
  parameter int N_SUM = 5,
  localparam int N_TERM = N_SUM + 3,
  localparam int CFG_W  = N_TERM * 2 * N_IN + N_SUM + MODE_W
) (
  input logic              gclk,
  input logic              rst_n,
  input logic              rst_sync_n,
  input logic [CFG_W-1:0]  cfg,
  input logic [N_TERM-1:0] terms,
  input logic              sum_pol,
  input logic              reg_q,
  input logic              g_oe,
  input logic              pad_out,
  input logic              pad_oe
);
  mc_mode_t mode;
  assign mode = cfg[CFG_W-1 -: MODE_W];

  logic d_on_gclk;
  logic t_on_gclk;
  assign d_on_gclk = !mode.bypass && !mode.toggle_mode && !mode.clk_from_term && !mode.clr_from_term;
  assign t_on_gclk = !mode.bypass &&  mode.toggle_mode && !mode.clk_from_term && !mode.clr_from_term;

  assert_bypass_path_R4: assert property (@(posedge gclk) disable iff (!rst_sync_n)
    mode.bypass |-> (pad_out == sum_pol));

  assert_d_load_R5: assert property (@(posedge gclk) disable iff (!rst_sync_n)
    d_on_gclk |=> (reg_q == $past(sum_pol)));

  assert_t_toggle_R6: assert property (@(posedge gclk) disable iff (!rst_sync_n)
    t_on_gclk |=> (reg_q == ($past(reg_q) ^ $past(sum_pol))));

  assert_global_clear_R8: assert property (@(posedge gclk)
    (!rst_sync_n && !mode.clr_from_term) |-> (reg_q == 1'b0));

  assert_term_clear_R9: assert property (@(posedge gclk) disable iff (!rst_sync_n)
    (mode.clr_from_term && terms[N_SUM+1]) |-> (reg_q == 1'b0));

  assert_oe_source_R10: assert property (@(posedge gclk) disable iff (!rst_sync_n)
    pad_oe == (mode.oe_from_term ? terms[N_SUM+2] : g_oe));
endmodule

bind mc_macrocell mc_macrocell_chk #(.N_IN(N_IN), .N_SUM(N_SUM)) i_chk (
  .gclk       (gclk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .cfg        (cfg),
  .terms      (terms),
  .sum_pol    (sum_pol),
  .reg_q      (reg_q),
  .g_oe       (g_oe),
  .pad_out    (pad_out),
  .pad_oe     (pad_oe)
);

// File: tb/test_mc_macrocell.sv
module test_mc_macrocell;
  localparam int CLK_PERIOD = 10;
  localparam int N_IN   = 8;
  localparam int N_SUM  = 5;
  localparam int N_LIT  = 2 * N_IN;
  localparam int N_TERM = N_SUM + 3;
  localparam int XP_W   = N_TERM * N_LIT;
  localparam int CFG_W  = XP_W + N_SUM + 6;

  // mode bits {oe_term, clr_term, clk_term, toggle, bypass, invert}
  localparam logic [5:0] M_INV = 6'b000001;
  localparam logic [5:0] M_BYP = 6'b000010;
  localparam logic [5:0] M_TOG = 6'b000100;
  localparam logic [5:0] M_CKT = 6'b001000;
  localparam logic [5:0] M_CLT = 6'b010000;
  localparam logic [5:0] M_OET = 6'b100000;

  // {input pattern, expected pad_out} for the bypass table configuration
  localparam logic [8:0] VEC [8] = '{
    {8'h00, 1'b0}, {8'h03, 1'b1}, {8'h08, 1'b1}, {8'h0C, 1'b0},
    {8'h10, 1'b0}, {8'hFF, 1'b1}, {8'h01, 1'b0}, {8'hF4, 1'b0}
  };

  logic             gclk;
  logic             rst_n;
  logic             g_oe;
  logic [N_IN-1:0]  in_bus;
  logic [CFG_W-1:0] cfg;
  logic             pad_out;
  logic             pad_oe;

  int checks = 0;
  int fails  = 0;

  mc_macrocell #(.N_IN(N_IN), .N_SUM(N_SUM)) i_mc_macrocell (
    .gclk(gclk), .rst_n(rst_n), .g_oe(g_oe), .in_bus(in_bus),
    .cfg(cfg), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  initial gclk = 1'b0;
  always #(CLK_PERIOD/2) gclk = ~gclk;

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  function automatic logic [CFG_W-1:0] put_term(input logic [CFG_W-1:0] c, input int t,
                                                input logic [N_LIT-1:0] m);
    c[t*N_LIT +: N_LIT] = m;
    return c;
  endfunction

  function automatic logic [CFG_W-1:0] put_ctl(input logic [CFG_W-1:0] c,
                                               input logic [N_SUM-1:0] admit, input logic [5:0] mode);
    c[XP_W +: N_SUM]  = admit;
    c[CFG_W-1 -: 6]   = mode;
    return c;
  endfunction

  function automatic logic ref_term(input logic [CFG_W-1:0] c, input int t, input logic [N_IN-1:0] x);
    logic r;
    r = 1'b1;
    for (int i = 0; i < N_IN; i++) begin
      if (c[t*N_LIT + i] && !x[i]) r = 1'b0;
      if (c[t*N_LIT + N_IN + i] && x[i]) r = 1'b0;
    end
    return r;
  endfunction

  function automatic logic ref_sum(input logic [CFG_W-1:0] c, input logic [N_IN-1:0] x);
    logic s;
    s = 1'b0;
    for (int t = 0; t < N_SUM; t++)
      if (c[XP_W + t] && ref_term(c, t, x)) s = 1'b1;
    return s ^ c[CFG_W-6];
  endfunction

  // reprogram under global reset, release and wait until the first load is done
  task automatic apply_cfg(input logic [CFG_W-1:0] c);
    @(negedge gclk);
    rst_n = 1'b0;
    cfg   = c;
    repeat (2) @(negedge gclk);
    rst_n = 1'b1;
    repeat (3) @(negedge gclk);
  endtask

  task automatic random_run(input logic [5:0] mode, input string req);
    logic [CFG_W-1:0] c;
    logic exp_q;
    c = '0;
    for (int t = 0; t < N_SUM; t++)
      c = put_term(c, t, (16'h1 << ($urandom % 16)) | (16'h1 << ($urandom % 16)));
    c = put_ctl(c, N_SUM'($urandom), mode | {5'b0, 1'($urandom)});
    in_bus = N_IN'($urandom);
    apply_cfg(c);
    exp_q = ref_sum(c, in_bus);
    for (int k = 0; k < 30; k++) begin
      check(req, pad_out, exp_q);
      in_bus = N_IN'($urandom);
      if (mode & M_TOG) exp_q = exp_q ^ ref_sum(c, in_bus);
      else              exp_q = ref_sum(c, in_bus);
      @(negedge gclk);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge gclk);
    checks++;
    fails++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : stim
    logic [CFG_W-1:0] c;
    rst_n  = 1'b0;
    g_oe   = 1'b0;
    in_bus = '0;
    cfg    = '0;

    // reset state and release timing (R8), then D load (R5)
    c = put_ctl(put_term('0, 0, 16'h0001), 5'b00001, 6'b0);
    cfg = c;
    in_bus = 8'h01;
    repeat (3) @(negedge gclk);
    check("R8 reset state", pad_out, 1'b0);
    check("R10 global oe low", pad_oe, 1'b0);
    rst_n = 1'b1;
    @(negedge gclk);
    check("R8 held after release 1", pad_out, 1'b0);
    @(negedge gclk);
    check("R8 held after release 2", pad_out, 1'b0);
    @(negedge gclk);
    check("R5 first load", pad_out, 1'b1);
    #2 rst_n = 1'b0;
    #1 check("R8 asynchronous clear", pad_out, 1'b0);
    @(negedge gclk);
    rst_n = 1'b1;
    repeat (3) @(negedge gclk);
    check("R5 reload after clear", pad_out, 1'b1);

    // bypass truth table: term0 = in0&in1, term1 = ~in2&in3, term2 = in4 not admitted (R1 R2 R4)
    c = put_term('0, 0, 16'h0003);
    c = put_term(c, 1, 16'h0408);
    c = put_term(c, 2, 16'h0010);
    c = put_ctl(c, 5'b00011, M_BYP);
    apply_cfg(c);
    for (int v = 0; v < 8; v++) begin
      in_bus = VEC[v][8:1];
      #1 check("R1 R2 R4 bypass table", pad_out, VEC[v][0]);
    end

    // inversion (R3)
    apply_cfg(put_ctl(c, 5'b00011, M_BYP | M_INV));
    in_bus = 8'h03;
    #1 check("R3 inverted sum one", pad_out, 1'b0);
    in_bus = 8'h0C;
    #1 check("R3 inverted sum zero", pad_out, 1'b1);

    // empty term is constant 1, contradictory term constant 0 (R1)
    apply_cfg(put_ctl('0, 5'b01000, M_BYP));
    in_bus = 8'h00;
    #1 check("R1 empty term in=00", pad_out, 1'b1);
    in_bus = 8'hFF;
    #1 check("R1 empty term in=FF", pad_out, 1'b1);
    apply_cfg(put_ctl(put_term('0, 0, 16'h0101), 5'b00001, M_BYP));
    in_bus = 8'h00;
    #1 check("R1 contradictory term in=00", pad_out, 1'b0);
    in_bus = 8'hFF;
    #1 check("R1 contradictory term in=FF", pad_out, 1'b0);

    // random configurations against the reference model
    for (int r = 0; r < 3; r++) random_run(6'b0,  "R5 D mode random");
    for (int r = 0; r < 3; r++) random_run(M_TOG, "R6 T mode random");
    for (int r = 0; r < 2; r++) random_run(M_BYP, "R4 bypass random");

    // product-term clock on in7 (R7)
    c = put_term(put_term('0, 0, 16'h0001), N_SUM, 16'h0080);
    in_bus = 8'h00;
    apply_cfg(put_ctl(c, 5'b00001, M_CKT));
    in_bus = 8'h01;
    repeat (2) @(negedge gclk);
    check("R7 gclk ignored", pad_out, 1'b0);
    in_bus = 8'h81;
    #1 check("R7 load on term edge", pad_out, 1'b1);
    in_bus = 8'h01;
    #1 in_bus = 8'h00;
    repeat (2) @(negedge gclk);
    check("R7 hold without term edge", pad_out, 1'b1);
    in_bus = 8'h80;
    #1 check("R7 second term edge", pad_out, 1'b0);

    // product-term clear on in6 (R9)
    c = put_term(put_term('0, 0, 16'h0001), N_SUM + 1, 16'h0040);
    in_bus = 8'h01;
    apply_cfg(put_ctl(c, 5'b00001, M_CLT));
    check("R9 loaded before clear", pad_out, 1'b1);
    rst_n = 1'b0;
    #1 check("R9 global reset ignored", pad_out, 1'b1);
    repeat (2) @(negedge gclk);
    check("R9 global reset ignored over edges", pad_out, 1'b1);
    rst_n = 1'b1;
    repeat (3) @(negedge gclk);
    #2 in_bus = 8'h41;
    #1 check("R9 term clear asynchronous", pad_out, 1'b0);
    @(negedge gclk);
    check("R9 clear held over edge", pad_out, 1'b0);
    in_bus = 8'h01;
    @(negedge gclk);
    check("R9 load after clear drops", pad_out, 1'b1);

    // output enable source (R10), oe term = ~in5
    apply_cfg(put_ctl('0, 5'b0, M_BYP));
    g_oe = 1'b1;
    #1 check("R10 global oe high", pad_oe, 1'b1);
    g_oe = 1'b0;
    #1 check("R10 global oe low", pad_oe, 1'b0);
    apply_cfg(put_ctl(put_term('0, N_SUM + 2, 16'h2000), 5'b0, M_BYP | M_OET));
    in_bus = 8'h00;
    g_oe = 1'b0;
    #1 check("R10 term oe high", pad_oe, 1'b1);
    in_bus = 8'h20;
    g_oe = 1'b1;
    #1 check("R10 term oe low, global ignored", pad_oe, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule